// File: doc/BRIEF.md
# Memory Activity Power-Down Monitor

This block sits next to the control inputs of an asynchronous static memory. It decides when the array must run at full active current and when it may fall back to standby. It samples the active-low chip enable, the active-low write enable, the address bus and the write-data bus. Each input passes through a two-flop synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier.

A qualifying edge, called a trigger, raises the active-power request. The request then stays high for a programmable number of clock cycles. Every new trigger reloads that interval to its full length. Power therefore follows the rate of memory cycles, not the length of time the chip stays selected. A separate registered output reports that the memory is deselected, which is its standby state.

All pins are plain control and status levels. The block has no streaming interface and no back-pressure. In the requirements below, "3 cycles later" means that an input changed between clock edges is first visible on the outputs after the third following rising edge: two synchronizer flops and one output register.

Top module: `mempwr_monitor`

## Requirements
- R1: While `rst_n` is low, `pwr_active` is 0 and `deselected` is 1. Reset clears the interval counter.
- R2: A falling edge on `ce_n` is a trigger. `pwr_active` rises 3 cycles after the edge.
- R3: A falling edge on `we_n` is a trigger only while `ce_n` is 0. A falling edge on `we_n` while `ce_n` is 1 leaves `pwr_active` at 0.
- R4: Any change on any `addr` bit is a trigger only while `ce_n` is 0. An address change while `ce_n` is 1 leaves `pwr_active` at 0.
- R5: Any change on any `din` bit is a trigger only while both `ce_n` and `we_n` are 0. A data change while `we_n` is 1 leaves `pwr_active` at 0.
- R6: After the last trigger, `pwr_active` stays high for exactly `DELAY` cycles and then returns to 0 on its own, even if `ce_n` stays low.
- R7: A trigger that arrives while `pwr_active` is high restarts the full `DELAY` interval, timed from that new trigger.
- R8: `deselected` equals the synchronized `ce_n`, 3 cycles after `ce_n` changes.
- R9: Rising edges on `ce_n` and on `we_n` are not triggers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Memory chip enable, active low |
| we_n | input | 1 | Memory write enable, active low |
| addr | input | ADDR_W (14) | Memory address bus |
| din | input | DATA_W (4) | Memory write-data bus |
| pwr_active | output | 1 | Active-power request, registered |
| deselected | output | 1 | Standby indication (chip enable high), registered |

## Verification
The hardest case to reach is a retrigger that lands just before the interval would expire. The request must then stay high across the point where the first interval ends, and must fall exactly `DELAY` cycles after the second trigger. The bench reaches this case in steps. It first selects the chip and lets the request settle back to idle. It then fires one address change, and fires a second address change exactly `DELAY-2` cycles later. It checks the output at the cycle where the first interval would have ended, and again at the two cycles around the new expiry.

The ignored-edge cases need a separate setup. For each one, the bench first forces the gating level and waits out every pending interval. Only then does it apply the edge, so any wrongly accepted trigger shows up as a rise on `pwr_active`.

// File: rtl/mempwr_pkg.sv
package mempwr_pkg;

  // Reasons an activity trigger fired in a given cycle
  typedef struct packed {
    logic sel_fall;   // chip enable went active
    logic wr_fall;    // write enable went active while selected
    logic addr_move;  // address changed while selected
    logic data_move;  // write data changed during a write
  } cause_t;

  function automatic logic any_cause(cause_t c);
    return c.sel_fall | c.wr_fall | c.addr_move | c.data_move;
  endfunction

endpackage

// File: rtl/mempwr_sync.sv
module mempwr_sync #(
  parameter int              W       = 8,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/mempwr_edge.sv
module mempwr_edge
  import mempwr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_s,
  input  logic              we_n_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] din_s,
  output cause_t            cause,
  output logic              trig
);

  logic              ce_n_p;
  logic              we_n_p;
  logic [ADDR_W-1:0] addr_p;
  logic [DATA_W-1:0] din_p;

  // Previous-cycle copies; reset to the idle (deselected) levels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_p <= 1'b1;
      we_n_p <= 1'b1;
      addr_p <= '0;
      din_p  <= '0;
    end else begin
      ce_n_p <= ce_n_s;
      we_n_p <= we_n_s;
      addr_p <= addr_s;
      din_p  <= din_s;
    end
  end

  logic sel;
  logic wr;
  assign sel = ~ce_n_s;
  assign wr  = sel & ~we_n_s;

  always_comb begin
    cause           = '0;
    cause.sel_fall  = ce_n_p & ~ce_n_s;
    cause.wr_fall   = sel & we_n_p & ~we_n_s;
    cause.addr_move = sel & (|(addr_s ^ addr_p));
    cause.data_move = wr & (|(din_s ^ din_p));
  end

  assign trig = any_cause(cause);

endmodule

// File: rtl/mempwr_timer.sv
module mempwr_timer #(
  parameter int DELAY = 64,
  localparam int CNT_W = $clog2(DELAY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  output logic [CNT_W-1:0] cnt,
  output logic             active
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (trig) begin
      cnt    <= LOAD;
      active <= 1'b1;
    end else begin
      if (cnt != '0) cnt <= cnt - ONE;
      active <= (cnt > ONE);
    end
  end

endmodule

// File: rtl/mempwr_monitor.sv
module mempwr_monitor
  import mempwr_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 4,
  parameter int DELAY  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              pwr_active,
  output logic              deselected
);

  localparam int BUS_W = 2 + ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(DELAY + 1);
  localparam logic [BUS_W-1:0] IDLE_VAL = {2'b11, {(ADDR_W + DATA_W){1'b0}}};

  logic [BUS_W-1:0] bus_raw;
  logic [BUS_W-1:0] bus_s;

  assign bus_raw = {ce_n, we_n, addr, din};

  mempwr_sync #(
    .W       (BUS_W),
    .STAGES  (2),
    .RST_VAL (IDLE_VAL)
  ) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (bus_raw),
    .q     (bus_s)
  );

  logic              ce_n_s;
  logic              we_n_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] din_s;

  assign {ce_n_s, we_n_s, addr_s, din_s} = bus_s;

  cause_t cause;
  logic   trig;

  mempwr_edge #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) edge_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n_s (ce_n_s),
    .we_n_s (we_n_s),
    .addr_s (addr_s),
    .din_s  (din_s),
    .cause  (cause),
    .trig   (trig)
  );

  logic [CNT_W-1:0] cnt;

  mempwr_timer #(
    .DELAY (DELAY)
  ) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (trig),
    .cnt    (cnt),
    .active (pwr_active)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) deselected <= 1'b1;
    else        deselected <= ce_n_s;
  end

endmodule

// File: rtl/mempwr_monitor_chk.sv
module mempwr_monitor_chk #(
  parameter int DELAY = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_active,
  input logic             deselected,
  input logic             trig,
  input logic [CNT_W-1:0] cnt
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!pwr_active && deselected));

  // R2
  rise_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_active) |-> $past(trig));

  // R7
  trig_sets_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pwr_active);

  // R6
  fall_without_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_active) |-> !$past(trig));

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DELAY));

  // R8
  desel_no_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deselected |-> !$past(trig));

endmodule

bind mempwr_monitor mempwr_monitor_chk #(
  .DELAY (DELAY),
  .CNT_W (CNT_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_active (pwr_active),
  .deselected (deselected),
  .trig       (trig),
  .cnt        (cnt)
);

// File: tb/mempwr_monitor_tb_top.sv
`timescale 1ns/1ps
module mempwr_monitor_tb_top;

  localparam int ADDR_W = 14;
  localparam int DATA_W = 4;
  localparam int DELAY  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ce_n;
  logic              we_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] din;
  logic              pwr_active;
  logic              deselected;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mempwr_monitor #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DELAY  (DELAY)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .addr       (addr),
    .din        (din),
    .pwr_active (pwr_active),
    .deselected (deselected)
  );

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Advance n rising edges, then sit at the following falling edge
  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    edges(DELAY + 6);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; addr = '0; din = '0;
    edges(4);
    check("R1", "pwr_active in reset", pwr_active, 1'b0);
    check("R1", "deselected in reset", deselected, 1'b1);
    rst_n = 1'b1;
    edges(3);
    check("R1", "pwr_active after release", pwr_active, 1'b0);
  endtask

  task automatic t_sel_fall();
    ce_n = 1'b0;
    edges(2);
    check("R2", "not yet active", pwr_active, 1'b0);
    check("R8", "still deselected", deselected, 1'b1);
    edges(1);
    check("R2", "active after select", pwr_active, 1'b1);
    check("R8", "selected seen", deselected, 1'b0);
    edges(DELAY - 1);
    check("R6", "last active cycle", pwr_active, 1'b1);
    edges(1);
    check("R6", "dropped while selected", pwr_active, 1'b0);
    settle();
  endtask

  task automatic t_write_edge();
    we_n = 1'b0;
    edges(3);
    check("R3", "we fall while selected", pwr_active, 1'b1);
    settle();
    we_n = 1'b1;
    edges(3);
    check("R9", "we rise ignored", pwr_active, 1'b0);
    ce_n = 1'b1;
    edges(3);
    check("R9", "ce rise ignored", pwr_active, 1'b0);
    check("R8", "deselected after ce rise", deselected, 1'b1);
    settle();
    we_n = 1'b0;
    edges(3);
    check("R3", "we fall while deselected", pwr_active, 1'b0);
    we_n = 1'b1;
    settle();
  endtask

  task automatic t_addr();
    addr = 14'h2A5C;
    edges(3);
    check("R4", "addr move while deselected", pwr_active, 1'b0);
    ce_n = 1'b0;
    settle();
    addr = 14'h2A5D;
    edges(3);
    check("R4", "addr bit0 move while selected", pwr_active, 1'b1);
    settle();
    addr = 14'h0A5D;
    edges(3);
    check("R4", "addr msb move while selected", pwr_active, 1'b1);
    settle();
  endtask

  task automatic t_data();
    din = 4'h9;
    edges(3);
    check("R5", "din move with we high", pwr_active, 1'b0);
    we_n = 1'b0;
    settle();
    din = 4'h1;
    edges(3);
    check("R5", "din move during write", pwr_active, 1'b1);
    settle();
    we_n = 1'b1;
    settle();
  endtask

  task automatic t_retrig();
    addr = 14'h0001;
    edges(DELAY - 2);
    check("R7", "active before retrigger", pwr_active, 1'b1);
    addr = 14'h0002;
    edges(5);
    check("R7", "past first expiry", pwr_active, 1'b1);
    edges(DELAY - 3);
    check("R7", "last cycle of reload", pwr_active, 1'b1);
    edges(1);
    check("R7", "drop after reload", pwr_active, 1'b0);
    ce_n = 1'b1;
    settle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sel_fall();
    t_write_edge();
    t_addr();
    t_data();
    ce_n = 1'b0;
    settle();
    t_retrig();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule